// File: doc/BRIEF.md
# Three-PLL Fast Frequency-Stepping Controller

This block lets a core change its clock frequency in one step, without waiting for a PLL to relock. It manages three clock sources. Each source has a lock flag coming in and a divider value going out, and each runs at its own frequency. One source drives the core. In the default bracketing variant, a second source is kept locked one frequency step above the running one and the third one step below. The frequency steps are spaced about 3% apart. Repeated steps therefore reach every frequency in the range.

An operating-point controller sends single-cycle up or down requests. When a request is accepted, the block moves the 2-bit clock select to the neighbour that is already locked. It then waits for the glitch-free clock multiplexer to acknowledge the change. After the acknowledge, it rotates a role register that maps the active, upper and lower roles onto physical sources, and it reprograms the divider of the source that has to move so that the new frequency is bracketed again. That source then relocks in the background while the core runs.

A parameter selects a simpler variant. In that variant the three sources sit at fixed, pre-locked frequencies and the block only moves the select among them. The block also reports the current step index and a ready flag.

Top module: `pll_step_ctrl`

## Requirements
- R1: Out of reset, the bracketing variant has the following state:
  - step index RESET_STEP;
  - select 0;
  - upper role on source 1 and lower role on source 2;
  - divider fields `pllDiv[i*DIV_W +: DIV_W]` equal to DIV_BASE plus the step the source is assigned: RESET_STEP, RESET_STEP+1 and RESET_STEP-1 for sources 0, 1 and 2.
- R2: The block samples an up (down) request at a clock edge. If ready is high, `clkSel` takes the index of the upper (lower) role source at the next edge.
- R3: The step index, the role mapping and the divider values change only at the edge that samples `selAck` high after a select change. While the acknowledge is outstanding they hold.
- R4: At that edge the following happens:
  - the step index moves by one;
  - the former neighbour becomes active;
  - the former active source takes the opposite neighbour role and keeps its divider;
  - the remaining source gets divider DIV_BASE plus the new step plus one (up) or minus one (down).
- R5: A request that arrives while either neighbour source reports unlocked does not move the select. It is held pending and is carried out once both locks return.
- R6: An up request at step NUM_STEPS-1 and a down request at step 0 are discarded. They change neither the select, the step nor the dividers.
- R7: A cycle in which up and down are both asserted is treated as no request.
- R8: `ready` equals the logical AND of the lock flags of the upper and lower role sources.
- R9: A bracketing divider is clamped to the range ends: at the top step the upper source holds DIV_BASE+NUM_STEPS-1, and at step 0 the lower source holds DIV_BASE.
- R10: In the fixed variant the behaviour is as follows:
  - source i permanently holds divider DIV_BASE+FIX_STEPi;
  - the reset select is 1;
  - up and down move the select by one source;
  - requests beyond source 2 or below source 0 are discarded;
  - the step index reports FIX_STEP of the active source;
  - ready is the AND of all three locks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReq | input | 1 | One-cycle request for one step faster |
| downReq | input | 1 | One-cycle request for one step slower |
| pllLock | input | 3 | Lock flag of each source |
| selAck | input | 1 | Pulse from the clock multiplexer once a select change has taken effect |
| clkSel | output | 2 | Index of the source that drives the core |
| pllDiv | output | 3*DIV_W | Divider value for each source, source i in bits i*DIV_W upward |
| stepIdx | output | STEP_W | Current frequency step index |
| ready | output | 1 | Both neighbour sources locked |

## Verification
The bench walks the step index to both ends of the range. A design without clamping would program a bracketing divider outside the range there, and a design that did not discard edge requests would wrap the step index. The bench holds off the multiplexer acknowledge for several cycles and watches that the dividers stay put. A design that reprograms early would detune a source before the core has left it. The bench also forces a neighbour unlocked while a request arrives. A block that does not hold the request would either switch onto an unlocked clock or lose the request. Simultaneous up and down, a long run of random steps checked against a bench model of the role rotation, and the fixed variant's edge refusals cover the remaining cases.

// File: rtl/pll_step_pkg.sv
package pll_step_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SWITCH = 1'b1
  } step_state_e;

  typedef struct packed {
    logic start;
    logic commit;
    logic dirUp;
  } step_strobe_t;

  localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/pll_step_ctrl_fsm.sv
module pll_step_ctrl_fsm
  import pll_step_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         upReq,
  input  logic         downReq,
  input  logic         selAck,
  input  logic         nbrLocked,
  input  logic         atTop,
  input  logic         atBottom,
  output step_strobe_t strobe
);

  step_state_e stateQ;
  logic        pendValidQ;
  logic        pendUpQ;
  logic        dirQ;

  logic newReq;
  logic legal;
  logic serve;
  logic drop;
  logic commit;

  // R7: both directions at once cancel out
  assign newReq = upReq ^ downReq;
  // R6: range test is made when the request is about to be served
  assign legal  = pendUpQ ? !atTop : !atBottom;
  // R5: a legal request waits for both neighbour locks
  assign serve  = (stateQ == ST_IDLE) && pendValidQ && legal && nbrLocked;
  assign drop   = (stateQ == ST_IDLE) && pendValidQ && !legal;
  assign commit = (stateQ == ST_SWITCH) && selAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      pendValidQ <= 1'b0;
      pendUpQ    <= 1'b0;
      dirQ       <= 1'b0;
    end else begin
      if (newReq) begin
        pendValidQ <= 1'b1;
        pendUpQ    <= upReq;
      end else if (serve || drop) begin
        pendValidQ <= 1'b0;
      end
      if (serve) begin
        stateQ <= ST_SWITCH;
        dirQ   <= pendUpQ;
      end else if (commit) begin
        stateQ <= ST_IDLE;
      end
    end
  end

  always_comb begin
    strobe.start  = serve;
    strobe.commit = commit;
    strobe.dirUp  = serve ? pendUpQ : dirQ;
  end

  a_r5_start_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> nbrLocked);

  a_r3_commit_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> selAck);

  a_r2_no_back_to_back_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> !strobe.start);

  a_r6_no_start_past_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> (strobe.dirUp ? !atTop : !atBottom));

endmodule

// File: rtl/pll_step_ctrl_dp.sv
module pll_step_ctrl_dp
  import pll_step_pkg::*;
#(
  parameter int NUM_STEPS  = 24,
  parameter int RESET_STEP = 12,
  parameter int DIV_W      = 8,
  parameter int DIV_BASE   = 40,
  parameter bit FIXED_MODE = 1'b0,
  parameter int FIX_STEP0  = 4,
  parameter int FIX_STEP1  = 12,
  parameter int FIX_STEP2  = 20,
  localparam int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  step_strobe_t               strobe,
  input  logic [NUM_SRC-1:0]         pllLock,
  output logic [1:0]                 clkSel,
  output logic [STEP_W-1:0]          stepIdx,
  output logic [NUM_SRC*DIV_W-1:0]   pllDiv,
  output logic                       nbrLocked,
  output logic                       atTop,
  output logic                       atBottom
);

  localparam int MAX_STEP = NUM_STEPS - 1;
  localparam int RST_HI   = (RESET_STEP >= MAX_STEP) ? MAX_STEP : RESET_STEP + 1;
  localparam int RST_LO   = (RESET_STEP <= 0) ? 0 : RESET_STEP - 1;

  function automatic logic [DIV_W-1:0] toDiv(input int s);
    return DIV_W'(DIV_BASE + s);
  endfunction

  logic [3:0] lockExt;
  assign lockExt = {1'b0, pllLock};

  generate
    if (!FIXED_MODE) begin : g_bracket
      logic [STEP_W-1:0] stepQ;
      logic [1:0]        actQ, hiQ, loQ, selQ;
      logic [DIV_W-1:0]  divQ [NUM_SRC];
      logic [1:0]        farSrc;
      int                newStepI;
      int                farStepI;

      always_comb begin
        newStepI = strobe.dirUp ? int'(stepQ) + 1 : int'(stepQ) - 1;
        if (strobe.dirUp) farStepI = (newStepI >= MAX_STEP) ? MAX_STEP : newStepI + 1;
        else              farStepI = (newStepI <= 0) ? 0 : newStepI - 1;
        // the source leaving the far side gets reprogrammed
        farSrc = strobe.dirUp ? loQ : hiQ;
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stepQ   <= STEP_W'(RESET_STEP);
          actQ    <= 2'd0;
          hiQ     <= 2'd1;
          loQ     <= 2'd2;
          selQ    <= 2'd0;
          divQ[0] <= toDiv(RESET_STEP);
          divQ[1] <= toDiv(RST_HI);
          divQ[2] <= toDiv(RST_LO);
        end else begin
          if (strobe.start) begin
            selQ <= strobe.dirUp ? hiQ : loQ;
          end
          if (strobe.commit) begin
            stepQ <= STEP_W'(newStepI);
            if (strobe.dirUp) begin
              actQ <= hiQ;
              loQ  <= actQ;
              hiQ  <= loQ;
            end else begin
              actQ <= loQ;
              hiQ  <= actQ;
              loQ  <= hiQ;
            end
            for (int i = 0; i < NUM_SRC; i++) begin
              if (farSrc == 2'(i)) divQ[i] <= toDiv(farStepI);
            end
          end
        end
      end

      for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_div
        assign pllDiv[gi*DIV_W +: DIV_W] = divQ[gi];

        a_r9_div_in_range: assert property (@(posedge clk) disable iff (!rstN)
          (divQ[gi] >= toDiv(0)) && (divQ[gi] <= toDiv(MAX_STEP)));
      end

      assign clkSel    = selQ;
      assign stepIdx   = stepQ;
      assign nbrLocked = lockExt[hiQ] & lockExt[loQ];
      assign atTop     = (int'(stepQ) == MAX_STEP);
      assign atBottom  = (stepQ == '0);

      a_r4_step_unit: assert property (@(posedge clk) disable iff (!rstN)
        (stepQ != $past(stepQ)) |->
          ((stepQ == STEP_W'($past(stepQ) + 1'b1)) || (stepQ == STEP_W'($past(stepQ) - 1'b1))));

      a_r2_sel_to_neighbour: assert property (@(posedge clk) disable iff (!rstN)
        (selQ != $past(selQ)) |-> ((selQ == $past(hiQ)) || (selQ == $past(loQ))));

      a_r4_active_is_selected: assert property (@(posedge clk) disable iff (!rstN)
        strobe.commit |=> (actQ == selQ));

      a_r4_roles_distinct: assert property (@(posedge clk) disable iff (!rstN)
        (actQ != hiQ) && (actQ != loQ) && (hiQ != loQ));

    end else begin : g_fixed
      logic [1:0] actQ, selQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          actQ <= 2'd1;
          selQ <= 2'd1;
        end else begin
          if (strobe.start) begin
            selQ <= strobe.dirUp ? actQ + 2'd1 : actQ - 2'd1;
          end
          if (strobe.commit) begin
            actQ <= selQ;
          end
        end
      end

      always_comb begin
        case (actQ)
          2'd0:    stepIdx = STEP_W'(FIX_STEP0);
          2'd2:    stepIdx = STEP_W'(FIX_STEP2);
          default: stepIdx = STEP_W'(FIX_STEP1);
        endcase
      end

      assign pllDiv[0*DIV_W +: DIV_W] = toDiv(FIX_STEP0);
      assign pllDiv[1*DIV_W +: DIV_W] = toDiv(FIX_STEP1);
      assign pllDiv[2*DIV_W +: DIV_W] = toDiv(FIX_STEP2);
      assign clkSel    = selQ;
      assign nbrLocked = &pllLock;
      assign atTop     = (actQ == 2'd2);
      assign atBottom  = (actQ == 2'd0);

      a_r10_sel_adjacent: assert property (@(posedge clk) disable iff (!rstN)
        (selQ != $past(selQ)) |->
          ((selQ == $past(actQ) + 2'd1) || (selQ == $past(actQ) - 2'd1)));

      a_r10_sel_valid: assert property (@(posedge clk) disable iff (!rstN)
        selQ != 2'd3);
    end
  endgenerate

endmodule

// File: rtl/pll_step_ctrl.sv
module pll_step_ctrl
  import pll_step_pkg::*;
#(
  parameter int NUM_STEPS  = 24,
  parameter int RESET_STEP = 12,
  parameter int DIV_W      = 8,
  parameter int DIV_BASE   = 40,
  parameter bit FIXED_MODE = 1'b0,
  parameter int FIX_STEP0  = 4,
  parameter int FIX_STEP1  = 12,
  parameter int FIX_STEP2  = 20,
  localparam int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     upReq,
  input  logic                     downReq,
  input  logic [2:0]               pllLock,
  input  logic                     selAck,
  output logic [1:0]               clkSel,
  output logic [3*DIV_W-1:0]       pllDiv,
  output logic [STEP_W-1:0]        stepIdx,
  output logic                     ready
);

  step_strobe_t strobe;
  logic         nbrLocked;
  logic         atTop;
  logic         atBottom;

  pll_step_ctrl_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .upReq     (upReq),
    .downReq   (downReq),
    .selAck    (selAck),
    .nbrLocked (nbrLocked),
    .atTop     (atTop),
    .atBottom  (atBottom),
    .strobe    (strobe)
  );

  pll_step_ctrl_dp #(
    .NUM_STEPS  (NUM_STEPS),
    .RESET_STEP (RESET_STEP),
    .DIV_W      (DIV_W),
    .DIV_BASE   (DIV_BASE),
    .FIXED_MODE (FIXED_MODE),
    .FIX_STEP0  (FIX_STEP0),
    .FIX_STEP1  (FIX_STEP1),
    .FIX_STEP2  (FIX_STEP2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pllLock   (pllLock),
    .clkSel    (clkSel),
    .stepIdx   (stepIdx),
    .pllDiv    (pllDiv),
    .nbrLocked (nbrLocked),
    .atTop     (atTop),
    .atBottom  (atBottom)
  );

  assign ready = nbrLocked;

  a_r3_step_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx != $past(stepIdx)) |-> $past(selAck));

  a_r3_div_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    (pllDiv != $past(pllDiv)) |-> $past(selAck));

  a_r6_step_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(stepIdx) < NUM_STEPS);

endmodule

// File: tb/pll_step_ctrl_bench.sv
module pll_step_ctrl_srcmodel #(
  parameter int DIV_W  = 8,
  parameter int LOCK_T = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         clkSel,
  input  logic [3*DIV_W-1:0] pllDiv,
  input  logic [2:0]         forceUnlock,
  input  int                 ackDelay,
  output logic [2:0]         pllLock,
  output logic               selAck
);
  logic [DIV_W-1:0] lockedDiv [3];
  int               lockCnt [3];
  logic [1:0]       lastSel;
  int               ackCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        lockedDiv[i] <= pllDiv[i*DIV_W +: DIV_W];
        lockCnt[i]   <= 0;
      end
      lastSel <= clkSel;
      ackCnt  <= 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (lockedDiv[i] != pllDiv[i*DIV_W +: DIV_W]) begin
          if (lockCnt[i] == LOCK_T - 1) begin
            lockedDiv[i] <= pllDiv[i*DIV_W +: DIV_W];
            lockCnt[i]   <= 0;
          end else begin
            lockCnt[i] <= lockCnt[i] + 1;
          end
        end else begin
          lockCnt[i] <= 0;
        end
      end
      lastSel <= clkSel;
      if (clkSel != lastSel) ackCnt <= ackDelay;
      else if (ackCnt > 0)   ackCnt <= ackCnt - 1;
    end
  end

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      pllLock[i] = (lockedDiv[i] == pllDiv[i*DIV_W +: DIV_W]) && !forceUnlock[i];
    end
  end

  assign selAck = (ackCnt == 1);
endmodule

module pll_step_ctrl_bench;
  localparam int NUM_STEPS = 24;
  localparam int RST_STEP  = 12;
  localparam int DIV_W     = 8;
  localparam int BASE      = 40;
  localparam int MAXS      = NUM_STEPS - 1;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int FIX0 = 4, FIX1 = 12, FIX2 = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              upReq = 0, downReq = 0;
  logic [2:0]        pllLock;
  logic              selAck;
  logic [1:0]        clkSel;
  logic [3*DIV_W-1:0] pllDiv;
  logic [STEP_W-1:0] stepIdx;
  logic              ready;
  logic [2:0]        forceUnlock = 3'b000;
  int                ackDelay = 2;

  logic              fUp = 0, fDown = 0;
  logic [2:0]        fLock;
  logic              fAck;
  logic [1:0]        fSel;
  logic [3*DIV_W-1:0] fDiv;
  logic [STEP_W-1:0] fStep;
  logic              fReady;
  int                fAckDelay = 2;

  pll_step_ctrl #(.NUM_STEPS(NUM_STEPS), .RESET_STEP(RST_STEP), .DIV_W(DIV_W),
                  .DIV_BASE(BASE), .FIXED_MODE(1'b0)) u_pll_step_ctrl (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq), .pllLock(pllLock),
    .selAck(selAck), .clkSel(clkSel), .pllDiv(pllDiv), .stepIdx(stepIdx), .ready(ready));

  pll_step_ctrl_srcmodel #(.DIV_W(DIV_W)) u_src (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .pllDiv(pllDiv), .forceUnlock(forceUnlock),
    .ackDelay(ackDelay), .pllLock(pllLock), .selAck(selAck));

  pll_step_ctrl #(.NUM_STEPS(NUM_STEPS), .RESET_STEP(RST_STEP), .DIV_W(DIV_W),
                  .DIV_BASE(BASE), .FIXED_MODE(1'b1), .FIX_STEP0(FIX0),
                  .FIX_STEP1(FIX1), .FIX_STEP2(FIX2)) u_pll_step_ctrl_fixed (
    .clk(clk), .rstN(rstN), .upReq(fUp), .downReq(fDown), .pllLock(fLock),
    .selAck(fAck), .clkSel(fSel), .pllDiv(fDiv), .stepIdx(fStep), .ready(fReady));

  pll_step_ctrl_srcmodel #(.DIV_W(DIV_W)) u_src_fixed (
    .clk(clk), .rstN(rstN), .clkSel(fSel), .pllDiv(fDiv), .forceUnlock(3'b000),
    .ackDelay(fAckDelay), .pllLock(fLock), .selAck(fAck));

  int errors = 0;
  int checks = 0;
  int expStep, expAct, expHi, expLo;
  int expDiv [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampS(input int s);
    if (s < 0) return 0;
    if (s > MAXS) return MAXS;
    return s;
  endfunction

  function automatic int divOf(input logic [3*DIV_W-1:0] v, input int i);
    return int'(v[i*DIV_W +: DIV_W]);
  endfunction

  task automatic modelCommit(input bit up);
    int a, h, l;
    a = expAct; h = expHi; l = expLo;
    if (up) begin
      expStep = expStep + 1;
      expAct = h; expLo = a; expHi = l;
      expDiv[expHi] = BASE + clampS(expStep + 1);
    end else begin
      expStep = expStep - 1;
      expAct = l; expHi = a; expLo = h;
      expDiv[expLo] = BASE + clampS(expStep - 1);
    end
  endtask

  task automatic checkState(input string req);
    chk(int'(stepIdx) == expStep, {req, " step"}, int'(stepIdx), expStep);
    chk(int'(clkSel) == expAct, {req, " select"}, int'(clkSel), expAct);
    for (int i = 0; i < 3; i++)
      chk(divOf(pllDiv, i) == expDiv[i], {req, " divider"}, divOf(pllDiv, i), expDiv[i]);
  endtask

  task automatic pulse(input bit which, input bit u, input bit d);
    @(negedge clk);
    if (which) begin fUp = u; fDown = d; end
    else begin upReq = u; downReq = d; end
    @(negedge clk);
    upReq = 0; downReq = 0; fUp = 0; fDown = 0;
  endtask

  task automatic stepOp(input bit up, input string req);
    bit legal;
    legal = up ? (expStep < MAXS) : (expStep > 0);
    pulse(0, up, !up);
    repeat (20) @(negedge clk);
    if (legal) modelCommit(up);
    checkState(req);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    expStep = RST_STEP; expAct = 0; expHi = 1; expLo = 2;
    expDiv[0] = BASE + RST_STEP; expDiv[1] = BASE + RST_STEP + 1; expDiv[2] = BASE + RST_STEP - 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R8 ready from locks
    checkState("R1");
    chk(ready == 1'b1, "R8 ready after reset", int'(ready), 1);

    // R2 select moves at the second edge after the request
    pulse(0, 1, 0);
    chk(int'(clkSel) == 0, "R2 select held at sampling edge", int'(clkSel), 0);
    @(negedge clk);
    chk(int'(clkSel) == expHi, "R2 select to upper source", int'(clkSel), expHi);
    repeat (20) @(negedge clk);
    modelCommit(1);
    checkState("R4 up rotation");
    chk(ready == 1'b1, "R8 ready after relock", int'(ready), 1);

    pulse(0, 0, 1);
    @(negedge clk);
    chk(int'(clkSel) == expLo, "R2 select to lower source", int'(clkSel), expLo);
    repeat (20) @(negedge clk);
    modelCommit(0);
    checkState("R4 down rotation");

    // R3 nothing moves while the acknowledge is outstanding
    ackDelay = 12;
    pulse(0, 1, 0);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(int'(stepIdx) == expStep, "R3 step held before ack", int'(stepIdx), expStep);
      chk(divOf(pllDiv, expLo) == expDiv[expLo], "R3 divider held before ack",
          divOf(pllDiv, expLo), expDiv[expLo]);
    end
    repeat (30) @(negedge clk);
    modelCommit(1);
    checkState("R3 commit after ack");
    ackDelay = 2;

    // R5 pending while a neighbour is unlocked, R8 ready follows it
    forceUnlock[expLo] = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R8 ready low with lower unlocked", int'(ready), 0);
    pulse(0, 1, 0);
    repeat (10) @(negedge clk);
    chk(int'(clkSel) == expAct, "R5 no switch while unlocked", int'(clkSel), expAct);
    chk(int'(stepIdx) == expStep, "R5 step held while unlocked", int'(stepIdx), expStep);
    forceUnlock = 3'b000;
    repeat (25) @(negedge clk);
    modelCommit(1);
    checkState("R5 pending request served");

    // R7 both directions together
    pulse(0, 1, 1);
    repeat (20) @(negedge clk);
    checkState("R7 up and down together ignored");

    // R9 and R6 at the top
    while (expStep < MAXS) stepOp(1, "R4 walk up");
    checkState("R9 upper clamp at top");
    chk(divOf(pllDiv, expHi) == BASE + MAXS, "R9 upper divider at top",
        divOf(pllDiv, expHi), BASE + MAXS);
    stepOp(1, "R6 up at top ignored");

    // R9 and R6 at the bottom
    while (expStep > 0) stepOp(0, "R4 walk down");
    chk(divOf(pllDiv, expLo) == BASE, "R9 lower divider at bottom",
        divOf(pllDiv, expLo), BASE);
    stepOp(0, "R6 down at bottom ignored");

    // R4 random stepping against the model
    for (int n = 0; n < 60; n++) begin
      stepOp(1'($urandom % 2), "R4 random step");
    end

    // R10 fixed variant
    chk(int'(fSel) == 1, "R10 fixed reset select", int'(fSel), 1);
    chk(int'(fStep) == FIX1, "R10 fixed reset step", int'(fStep), FIX1);
    chk(fReady == 1'b1, "R10 fixed ready", int'(fReady), 1);
    pulse(1, 1, 0);
    repeat (20) @(negedge clk);
    chk(int'(fSel) == 2, "R10 fixed up select", int'(fSel), 2);
    chk(int'(fStep) == FIX2, "R10 fixed up step", int'(fStep), FIX2);
    pulse(1, 1, 0);
    repeat (20) @(negedge clk);
    chk(int'(fSel) == 2, "R10 fixed up at top ignored", int'(fSel), 2);
    pulse(1, 0, 1);
    repeat (20) @(negedge clk);
    pulse(1, 0, 1);
    repeat (20) @(negedge clk);
    chk(int'(fSel) == 0, "R10 fixed down to source 0", int'(fSel), 0);
    chk(int'(fStep) == FIX0, "R10 fixed bottom step", int'(fStep), FIX0);
    pulse(1, 0, 1);
    repeat (20) @(negedge clk);
    chk(int'(fSel) == 0, "R10 fixed down at bottom ignored", int'(fSel), 0);
    chk(divOf(fDiv, 0) == BASE + FIX0, "R10 fixed divider 0", divOf(fDiv, 0), BASE + FIX0);
    chk(divOf(fDiv, 1) == BASE + FIX1, "R10 fixed divider 1", divOf(fDiv, 1), BASE + FIX1);
    chk(divOf(fDiv, 2) == BASE + FIX2, "R10 fixed divider 2", divOf(fDiv, 2), BASE + FIX2);

    finishRun();
  end
endmodule